// File: doc/BRIEF.md
# Sub-Addressed Indirect Register Bank

This block gives a host CPU a small set of control registers on a synchronous 8-bit bus. Three bus offsets are decoded. The first holds a configuration byte. The second holds a 3-bit select code. The third is a data window, and the select code decides which internal register that window reaches. Two 8-bit setup registers sit behind the window.

The two low select bits are kept as two physical copies. One copy is in the configuration register and the other is in the select register. A write through either register updates both copies, so they always read back the same. The top select bit is needed to reach the second setup register. Any write to the configuration register clears that top bit, whatever data is written.

Every register field is also driven on parallel outputs for the logic around the block. The block decodes the second setup register's low two bits into the reconfiguration timeout they stand for at the 5 Mbps line rate.

Top module: `subaddr_regbank`

## Requirements
- R1: On hardware reset every register reads 00h and every output is zero. This includes the first setup register. A reset asserted mid-run clears registers that were written before.
- R2: A write to offset 3 loads bits [2:0] of the data into the select code (`subad_o`). A read of offset 3 returns the code in bits [2:0], with bits [7:3] reading 0.
- R3: A write to offset 6 loads all 8 bits of the configuration register (`cfg_o`). It also loads data bits [1:0] into select code bits [1:0]. A read of offset 6 returns the configuration byte.
- R4: A write to offset 3 also copies data bits [1:0] into configuration bits [1:0] and leaves configuration bits [7:2] unchanged. At all times configuration bits [1:0] equal select code bits [1:0].
- R5: Every write to offset 6 clears select code bit 2, whatever the data.
- R6: With select code 001, reads and writes at offset 7 reach the first setup register (`setup1_o`).
- R7: With select code 100, reads and writes at offset 7 reach the second setup register (`setup2_o`).
- R8: With any other select code, a read at offset 7 returns 00h and a write at offset 7 changes no register.
- R9: `recon_sel_o` equals the second setup register's bits [1:0]. `recon_period_us_o` gives the timeout for that code in microseconds: 00 gives 420000, 01 gives 105000, 10 gives 52500, 11 gives 26250.
- R10: Read data is registered. It shows the addressed value one cycle after the read strobe and holds between reads. A read changes no register. Offsets other than 3, 6 and 7 read 00h.
- R11: A write at offset 7 leaves the select code and the configuration register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low hardware reset, asynchronous |
| bus_addr_i | input | 3 | Host bus offset |
| bus_wdata_i | input | 8 | Host write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_rdata_o | output | 8 | Registered read data |
| cfg_o | output | 8 | Configuration register |
| subad_o | output | 3 | Select code |
| setup1_o | output | 8 | First setup register |
| setup2_o | output | 8 | Second setup register |
| recon_sel_o | output | 2 | Reconfiguration timeout code |
| recon_period_us_o | output | 19 | Timeout for that code, in microseconds at 5 Mbps |

## Verification
A write is sampled on the rising edge where its strobe is high. Its effect on every register output, and on the mirrored select bits, is visible right after that edge, so it is due one cycle after the strobe. Read data passes through one more register and is also due one cycle after its read strobe. The timeout outputs are combinational from the second setup register and follow it in the same cycle. The bench drives strobes on falling edges, keeps each strobe high for exactly one rising edge, and samples on the next falling edge. Every expected value is therefore taken half a cycle after the edge that produced it.

// File: rtl/subaddr_regbank_pkg.sv
package subaddr_regbank_pkg;

  localparam int SUB_W     = 3;
  localparam int LO_W      = 2;
  localparam int PERIOD_W  = 19;
  localparam int RCN_W     = 2;

  // Timeout in microseconds for a reconfiguration code at the 5 Mbps rate.
  function automatic logic [PERIOD_W-1:0] recon_period_us(input logic [RCN_W-1:0] code);
    logic [PERIOD_W-1:0] base;
    base = PERIOD_W'(420000);
    case (code)
      2'b00:   recon_period_us = base;
      2'b01:   recon_period_us = base >> 2;
      2'b10:   recon_period_us = base >> 3;
      default: recon_period_us = base >> 4;
    endcase
  endfunction

  // Select-code value a configuration write leaves behind: top bit cleared.
  function automatic logic [SUB_W-1:0] code_after_cfg(input logic [LO_W-1:0] lo);
    code_after_cfg = {1'b0, lo};
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int ADDR_W    = 3,
  parameter int NUM_TGT   = 2,
  parameter logic [ADDR_W-1:0] OFS_CFG = 3'd6,
  parameter logic [ADDR_W-1:0] OFS_SUB = 3'd3,
  parameter logic [ADDR_W-1:0] OFS_WIN = 3'd7,
  parameter logic [NUM_TGT*subaddr_regbank_pkg::SUB_W-1:0] TGT_CODES = 6'b100_001
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic                                 wr_i,
  input  logic [subaddr_regbank_pkg::SUB_W-1:0] subad_i,
  output logic                                 cfg_we_o,
  output logic                                 sub_we_o,
  output logic                                 win_we_o,
  output logic [NUM_TGT-1:0]                   win_sel_o,
  output logic                                 win_hit_o
);
  import subaddr_regbank_pkg::*;

  assign cfg_we_o = wr_i && (addr_i == OFS_CFG);
  assign sub_we_o = wr_i && (addr_i == OFS_SUB);
  assign win_we_o = wr_i && (addr_i == OFS_WIN);

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    assign win_sel_o[t] = (subad_i == TGT_CODES[t*SUB_W +: SUB_W]);
  end
  assign win_hit_o = |win_sel_o;

  // R2: only one register write strobe at a time
  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_we_o, sub_we_o, win_we_o}));

  // R8: the window never reaches two targets at once
  p_one_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_sel_o));

endmodule

// File: rtl/regbank_subaddr.sv
module regbank_subaddr #(
  parameter int DATA_W = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 cfg_we_i,
  input  logic                                 sub_we_i,
  input  logic [DATA_W-1:0]                    wdata_i,
  output logic [DATA_W-1:0]                    cfg_o,
  output logic [subaddr_regbank_pkg::SUB_W-1:0] subad_o
);
  import subaddr_regbank_pkg::*;

  logic [DATA_W-1:0] cfg_q;
  logic [SUB_W-1:0]  sub_q;

  // Two physical copies of the low select bits, kept in step on every write.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      sub_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q <= wdata_i;
      sub_q <= code_after_cfg(wdata_i[LO_W-1:0]);
    end else if (sub_we_i) begin
      sub_q            <= wdata_i[SUB_W-1:0];
      cfg_q[LO_W-1:0]  <= wdata_i[LO_W-1:0];
    end
  end

  assign cfg_o   = cfg_q;
  assign subad_o = sub_q;

  // R4: the two copies of the low select bits always agree
  p_lo_mirror_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[LO_W-1:0] == sub_q[LO_W-1:0]);

  // R4: a select write leaves the upper configuration bits alone
  p_cfg_hi_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_we_i && !cfg_we_i) |=> $stable(cfg_q[DATA_W-1:LO_W]));

  // R5: a configuration write always clears the top select bit
  p_top_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !sub_q[SUB_W-1]);

  // R11: with no write strobe for this module both registers hold
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !sub_we_i) |=> ($stable(cfg_q) && $stable(sub_q)));

endmodule

// File: rtl/regbank_setup.sv
module regbank_setup #(
  parameter int DATA_W  = 8,
  parameter int NUM_TGT = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      win_we_i,
  input  logic [NUM_TGT-1:0]        win_sel_i,
  input  logic                      win_hit_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [NUM_TGT*DATA_W-1:0] regs_o,
  output logic [DATA_W-1:0]         win_rdata_o
);
  logic [NUM_TGT*DATA_W-1:0] regs_q;
  logic [DATA_W-1:0]         pick [NUM_TGT];

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[t*DATA_W +: DATA_W] <= '0;
      else if (win_we_i && win_sel_i[t])
        regs_q[t*DATA_W +: DATA_W] <= wdata_i;
    end
    assign pick[t] = win_sel_i[t] ? regs_q[t*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    win_rdata_o = '0;
    for (int t = 0; t < NUM_TGT; t++) win_rdata_o = win_rdata_o | pick[t];
  end

  assign regs_o = regs_q;

  // R8: a window write with no matching code changes no setup register
  p_miss_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_we_i && !win_hit_i) |=> $stable(regs_q));

  // R6: setup registers only move on a window write
  p_no_stray_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_we_i |=> $stable(regs_q));

endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OFS_CFG = 3'd6,
  parameter logic [ADDR_W-1:0] OFS_SUB = 3'd3,
  parameter logic [ADDR_W-1:0] OFS_WIN = 3'd7
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 rd_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [DATA_W-1:0]                    cfg_i,
  input  logic [subaddr_regbank_pkg::SUB_W-1:0] subad_i,
  input  logic [DATA_W-1:0]                    win_i,
  output logic [DATA_W-1:0]                    rdata_o
);
  import subaddr_regbank_pkg::*;

  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_val = '0;
    if (addr_i == OFS_CFG)      rd_val = cfg_i;
    else if (addr_i == OFS_SUB) rd_val[SUB_W-1:0] = subad_i;
    else if (addr_i == OFS_WIN) rd_val = win_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  // R10: read data holds between read strobes
  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));

  // R2: a select-register read never shows bits above the code
  p_sub_read_narrow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_SUB) |=> (rdata_q[DATA_W-1:SUB_W] == '0));

endmodule

// File: rtl/subaddr_regbank.sv
module subaddr_regbank #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OFS_SUB = 3'd3,
  parameter logic [ADDR_W-1:0] OFS_CFG = 3'd6,
  parameter logic [ADDR_W-1:0] OFS_WIN = 3'd7,
  parameter logic [2:0] CODE_SETUP1 = 3'b001,
  parameter logic [2:0] CODE_SETUP2 = 3'b100
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic [ADDR_W-1:0]                           bus_addr_i,
  input  logic [DATA_W-1:0]                           bus_wdata_i,
  input  logic                                        bus_wr_i,
  input  logic                                        bus_rd_i,
  output logic [DATA_W-1:0]                           bus_rdata_o,
  output logic [DATA_W-1:0]                           cfg_o,
  output logic [subaddr_regbank_pkg::SUB_W-1:0]        subad_o,
  output logic [DATA_W-1:0]                           setup1_o,
  output logic [DATA_W-1:0]                           setup2_o,
  output logic [subaddr_regbank_pkg::RCN_W-1:0]        recon_sel_o,
  output logic [subaddr_regbank_pkg::PERIOD_W-1:0]     recon_period_us_o
);
  import subaddr_regbank_pkg::*;

  localparam int NUM_TGT = 2;
  localparam logic [NUM_TGT*SUB_W-1:0] TGT_CODES = {CODE_SETUP2, CODE_SETUP1};

  logic                      cfg_we, sub_we, win_we, win_hit;
  logic [NUM_TGT-1:0]        win_sel;
  logic [SUB_W-1:0]          subad;
  logic [DATA_W-1:0]         cfg;
  logic [NUM_TGT*DATA_W-1:0] setup_regs;
  logic [DATA_W-1:0]         win_rdata;

  regbank_decode #(
    .ADDR_W(ADDR_W), .NUM_TGT(NUM_TGT),
    .OFS_CFG(OFS_CFG), .OFS_SUB(OFS_SUB), .OFS_WIN(OFS_WIN),
    .TGT_CODES(TGT_CODES)
  ) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(bus_addr_i), .wr_i(bus_wr_i), .subad_i(subad),
    .cfg_we_o(cfg_we), .sub_we_o(sub_we), .win_we_o(win_we),
    .win_sel_o(win_sel), .win_hit_o(win_hit)
  );

  regbank_subaddr #(.DATA_W(DATA_W)) u_subaddr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .sub_we_i(sub_we), .wdata_i(bus_wdata_i),
    .cfg_o(cfg), .subad_o(subad)
  );

  regbank_setup #(.DATA_W(DATA_W), .NUM_TGT(NUM_TGT)) u_setup (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .win_we_i(win_we), .win_sel_i(win_sel), .win_hit_i(win_hit),
    .wdata_i(bus_wdata_i), .regs_o(setup_regs), .win_rdata_o(win_rdata)
  );

  regbank_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_CFG(OFS_CFG), .OFS_SUB(OFS_SUB), .OFS_WIN(OFS_WIN)
  ) u_rdmux (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .cfg_i(cfg), .subad_i(subad), .win_i(win_rdata), .rdata_o(bus_rdata_o)
  );

  assign cfg_o             = cfg;
  assign subad_o           = subad;
  assign setup1_o          = setup_regs[0 +: DATA_W];
  assign setup2_o          = setup_regs[DATA_W +: DATA_W];
  assign recon_sel_o       = setup2_o[RCN_W-1:0];
  assign recon_period_us_o = recon_period_us(recon_sel_o);

  // R11: a window write never disturbs the select code
  p_win_keeps_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_we |=> $stable(subad_o));

  // R9: the timeout is one of the four legal values
  p_period_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recon_period_us_o inside {19'd420000, 19'd105000, 19'd52500, 19'd26250});

endmodule

// File: tb/subaddr_regbank_tb.sv
`timescale 1ns/1ps
module subaddr_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata, cfg, s1, s2;
  logic [2:0]  subad;
  logic [1:0]  rsel;
  logic [18:0] rper;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  subaddr_regbank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_rdata_o(rdata), .cfg_o(cfg),
    .subad_o(subad), .setup1_o(s1), .setup2_o(s2),
    .recon_sel_o(rsel), .recon_period_us_o(rper)
  );

  localparam logic [2:0] SUB = 3'd3, CFG = 3'd6, WIN = 3'd7;

  // {is_read, offset, data, expected read value}
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, SUB, 8'h01, 8'h00},  // R2 code 001
    {1'b1, SUB, 8'h00, 8'h01},  // R2
    {1'b0, WIN, 8'hA5, 8'h00},  // R6
    {1'b1, WIN, 8'h00, 8'hA5},  // R6
    {1'b0, SUB, 8'h04, 8'h00},  // R7 code 100
    {1'b0, WIN, 8'h3C, 8'h00},  // R7
    {1'b1, WIN, 8'h00, 8'h3C},  // R7
    {1'b0, CFG, 8'hF2, 8'h00},  // R3 R5
    {1'b1, SUB, 8'h00, 8'h02},  // R3 R5
    {1'b1, CFG, 8'h00, 8'hF2},  // R3
    {1'b1, WIN, 8'h00, 8'h00},  // R8 code 010
    {1'b0, WIN, 8'hFF, 8'h00},  // R8 ignored
    {1'b0, SUB, 8'h01, 8'h00},  // R8
    {1'b1, WIN, 8'h00, 8'hA5},  // R8 setup1 kept
    {1'b0, SUB, 8'h07, 8'h00},  // R4
    {1'b1, CFG, 8'h00, 8'hF3},  // R4
    {1'b1, WIN, 8'h00, 8'h00},  // R8 code 111
    {1'b1, 3'd0, 8'h00, 8'h00}, // R10 unmapped offset
    {1'b0, SUB, 8'hF9, 8'h00},  // R2 upper bits dropped
    {1'b1, SUB, 8'h00, 8'h01}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    logic [7:0] r;
    logic [18:0] per_exp;
    repeat (3) @(negedge clk);
    // R1: reset state while in reset and after release
    check("R1 cfg", cfg, 0); check("R1 subad", subad, 0);
    check("R1 setup1", s1, 0); check("R1 setup2", s2, 0);
    check("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 period", rper, 420000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        bus_read(VEC[i][18:16], r);
        check($sformatf("R2-R10 vector %0d", i), r, VEC[i][7:0]);
      end else begin
        bus_write(VEC[i][18:16], VEC[i][15:8]);
      end
    end

    // R4: select write keeps cfg upper bits, mirrors low bits
    bus_write(SUB, 8'h02);
    check("R4 cfg", cfg, 8'hF2); check("R4 subad", subad, 3'b010);

    // R5: configuration write with top bit set in data still clears it
    bus_write(SUB, 8'h04);
    check("R5 pre", subad, 3'b100);
    bus_write(CFG, 8'h07);
    check("R5 subad", subad, 3'b011); check("R3 cfg", cfg, 8'h07);

    // R9: each timeout code
    bus_write(SUB, 8'h04);
    for (int c = 0; c < 4; c++) begin
      bus_write(WIN, {6'h2A, c[1:0]});
      case (c)
        0: per_exp = 420000;
        1: per_exp = 105000;
        2: per_exp = 52500;
        default: per_exp = 26250;
      endcase
      check("R9 sel", rsel, c[1:0]);
      check("R9 period", rper, per_exp);
      check("R7 setup2", s2, {6'h2A, c[1:0]});
    end

    // R11: window write leaves code and cfg
    check("R11 subad", subad, 3'b100); check("R11 cfg", cfg, 8'h04);

    // R10: read data due one cycle after strobe, holds, reads have no effect
    @(negedge clk); addr = CFG; rd = 1'b1;
    @(negedge clk); rd = 1'b0; addr = SUB;
    check("R10 due", rdata, 8'h04);
    repeat (3) @(negedge clk);
    check("R10 hold", rdata, 8'h04);
    bus_read(WIN, r); bus_read(WIN, r);
    check("R10 no side effect", s2, 8'hAB);
    check("R10 read win", r, 8'hAB);

    // R1: reset mid-run clears written registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 setup1 mid", s1, 0); check("R1 setup2 mid", s2, 0);
    check("R1 cfg mid", cfg, 0); check("R1 rdata mid", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule